// File: doc/BRIEF.md
# Two-Phase Transition-Signalled Pipeline FIFO

This block is a clock-stepped behavioural model of a self-timed first-in first-out pipeline. Each of its stages has one control bit, which behaves as a Muller C-element, and one data register. Neighbouring stages talk through two-phase signalling. A change of level in either direction is one event, and the level itself means nothing. On every clock edge all C-elements are evaluated at once from the values they held before that edge. An item therefore moves forward by at most one stage per clock.

A producer offers an item by placing it on `in_data` and flipping `in_req`. The item has been taken when `in_ack` flips to match. A consumer sees a new item when `out_req` differs from `out_ack`, and it releases the item by flipping `out_ack`. The fill state is decoded from the control bits alone. The consumer's acknowledge level is treated as the last control bit of the chain.

Top module: `tsig_fifo`

## Requirements
- R1: After reset every control bit is 0, `in_ack` and `out_req` are 0, `empty` is 1 and `full` is 0.
- R2: A rising and a falling transition of `in_req` each count as exactly one offered item, and `in_ack` flips once for each accepted item and never without one pending.
- R3: A stage flips its control bit only when its predecessor's bit differs from its own and its successor's bit equals its own. While its successor has not acknowledged, the stage stays locked and changes neither its control bit nor its data.
- R4: A stage loads its predecessor's data on the same clock edge on which its control bit flips. `out_data` stays stable while `out_req` differs from `out_ack`.
- R5: Items leave in exactly the order in which they were accepted, with no loss and no duplication.
- R6: A request that arrives while the first stage is locked is held, not lost. When the full pipeline is released by one `out_ack` flip, the pending item is accepted (`in_ack` flips) exactly DEPTH clock edges later.
- R7: `empty` is 1 exactly when all control bits and the `out_ack` level are equal, that is, when no item is held.
- R8: `full` is 1 exactly when every adjacent pair in the chain of control bits followed by `out_ack` differs, that is, when DEPTH items are held.
- R9: An item offered to an empty FIFO with the consumer idle makes `in_ack` flip after 1 clock edge and `out_req` flip after DEPTH clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Update clock; all C-elements are evaluated on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_req | input | 1 | Producer request; each flip offers one item |
| in_data | input | WIDTH | Producer data, held stable while a request is pending |
| in_ack | output | 1 | Acknowledge to producer; each flip accepts one item |
| out_req | output | 1 | Request to consumer; each flip presents one item |
| out_data | output | WIDTH | Item presented to the consumer |
| out_ack | input | 1 | Consumer acknowledge; each flip releases the presented item |
| empty | output | 1 | No item held |
| full | output | 1 | DEPTH items held |

## Verification
A control bit that flips when it should not, or fails to flip, shows up at the ports in one of two ways. The occupancy decoded into `empty` and `full` stops matching the count of accepted minus released items on that same clock. Or `in_ack` or `out_req` flips without a matching event. A data register that loads on the wrong edge surfaces later, when its item reaches `out_data`, no more than DEPTH edges after it moves. It appears as an out-of-order or duplicated value. The bench keeps a queue of accepted items and compares the flags and the presented item against it on every clock. It also times the fall-through and release paths to the exact edge.

// File: rtl/tsig_fifo_pkg.sv
package tsig_fifo_pkg;

    // Decoded fill state of the control chain
    typedef enum logic [1:0] {
        FILL_PART  = 2'b00,
        FILL_EMPTY = 2'b01,
        FILL_FULL  = 2'b10
    } fill_e;

    // Muller C-element: follows its inputs when they agree, otherwise holds
    function automatic logic c_elem(input logic a, input logic b, input logic prev);
        return (a == b) ? a : prev;
    endfunction

endpackage

// File: rtl/tsig_stage.sv
module tsig_stage
    import tsig_fifo_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pred_ctl,
    input  logic             succ_ctl,
    input  logic [WIDTH-1:0] pred_data,
    output logic             ctl_q,
    output logic [WIDTH-1:0] data_q,
    output logic             fire
);

    typedef struct packed {
        logic             ctl;
        logic [WIDTH-1:0] data;
    } stage_t;

    stage_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        // C-element inputs: predecessor bit and inverted successor bit
        st_d.ctl = c_elem(pred_ctl, ~succ_ctl, st_q.ctl);
        fire     = (st_d.ctl != st_q.ctl);
        if (fire) begin
            st_d.data = pred_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_q  = st_q.ctl;
    assign data_q = st_q.data;

    AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q != succ_ctl) |=> ($stable(ctl_q) && $stable(data_q))); // R3

    AST_LOAD_ON_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q != $past(ctl_q)) |-> (data_q == $past(pred_data))); // R4

    AST_FLIP_NEEDS_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q != $past(ctl_q)) |-> ($past(pred_ctl) != $past(ctl_q))); // R3

endmodule

// File: rtl/tsig_status.sv
module tsig_status
    import tsig_fifo_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic [DEPTH-1:0] ctl,
    input  logic             sink_ctl,
    output logic             empty,
    output logic             full
);

    localparam int EXT_W = DEPTH + 1;

    logic [EXT_W-1:0] ext;
    logic [DEPTH-1:0] diff;
    fill_e            fill;

    assign ext = {sink_ctl, ctl};

    // diff[i] marks an item held in stage i
    for (genvar i = 0; i < DEPTH; i++) begin : g_diff
        assign diff[i] = ext[i] ^ ext[i+1];
    end

    always_comb begin
        if (diff == '0) begin
            fill = FILL_EMPTY;
        end else if (&diff) begin
            fill = FILL_FULL;
        end else begin
            fill = FILL_PART;
        end
    end

    assign empty = (fill == FILL_EMPTY);
    assign full  = (fill == FILL_FULL);

endmodule

// File: rtl/tsig_fifo.sv
module tsig_fifo
    import tsig_fifo_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_req,
    input  logic [WIDTH-1:0] in_data,
    output logic             in_ack,
    output logic             out_req,
    output logic [WIDTH-1:0] out_data,
    input  logic             out_ack,
    output logic             empty,
    output logic             full
);

    localparam int LAST = DEPTH - 1;

    logic [DEPTH-1:0] ctl;
    logic [DEPTH-1:0] pred_c;
    logic [DEPTH-1:0] succ_c;
    logic [DEPTH-1:0] fire;
    logic [WIDTH-1:0] pred_d [DEPTH];
    logic [WIDTH-1:0] data   [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign pred_c[i] = in_req;
            assign pred_d[i] = in_data;
        end else begin : g_body
            assign pred_c[i] = ctl[i-1];
            assign pred_d[i] = data[i-1];
        end
        if (i == LAST) begin : g_tail
            assign succ_c[i] = out_ack;
        end else begin : g_mid
            assign succ_c[i] = ctl[i+1];
        end

        tsig_stage #(.WIDTH(WIDTH)) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .pred_ctl (pred_c[i]),
            .succ_ctl (succ_c[i]),
            .pred_data(pred_d[i]),
            .ctl_q    (ctl[i]),
            .data_q   (data[i]),
            .fire     (fire[i])
        );

        if (i < LAST) begin : g_adj
            AST_NO_ADJ_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
                !(fire[i] && fire[i+1])); // R3
        end
    end

    tsig_status #(.DEPTH(DEPTH)) u_status (
        .ctl     (ctl),
        .sink_ctl(out_ack),
        .empty   (empty),
        .full    (full)
    );

    assign in_ack   = ctl[0];
    assign out_req  = ctl[LAST];
    assign out_data = data[LAST];

    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ack != $past(in_ack)) |-> ($past(in_req) != $past(in_ack))); // R2

    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req != out_ack) |=> ($stable(out_req) && $stable(out_data))); // R4

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full)); // R8

    AST_EMPTY_NO_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (out_req == out_ack)); // R7

endmodule

// File: tb/tsig_fifo_tb_top.sv
module tsig_fifo_tb_top;

    localparam int DEPTH = 4;
    localparam int WIDTH = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             in_req;
    logic [WIDTH-1:0] in_data;
    logic             in_ack;
    logic             out_req;
    logic [WIDTH-1:0] out_data;
    logic             out_ack;
    logic             empty;
    logic             full;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [WIDTH-1:0] q[$];
    logic             ia_prev;
    logic             oa;
    logic             pending;
    logic [WIDTH-1:0] pend_data;
    logic [WIDTH-1:0] next_val;
    logic [15:0]      lfsr;

    always #10 clk = ~clk;

    tsig_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_req  (in_req),
        .in_data (in_data),
        .in_ack  (in_ack),
        .out_req (out_req),
        .out_data(out_data),
        .out_ack (out_ack),
        .empty   (empty),
        .full    (full)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Reference update and comparison, once per clock at the falling edge
    task automatic sample_check();
        if (in_ack != ia_prev) begin
            check(pending, "R2 ack without pending request", 0, 1);
            if (pending) q.push_back(pend_data);
            pending = 0;
            ia_prev = in_ack;
        end
        check(empty == (q.size() == 0), "R7 empty flag", int'(empty), int'(q.size() == 0));
        check(full == (q.size() == DEPTH), "R8 full flag", int'(full), int'(q.size() == DEPTH));
        if (out_req != oa) begin
            check(q.size() > 0, "R5 item presented but none held", q.size(), 1);
            if (q.size() > 0)
                check(out_data == q[0], "R5 output order", int'(out_data), int'(q[0]));
        end
    endtask

    task automatic step();
        @(negedge clk);
        sample_check();
    endtask

    task automatic push(input logic [WIDTH-1:0] d);
        in_data   = d;
        in_req    = ~in_req;
        pend_data = d;
        pending   = 1;
    endtask

    task automatic pop();
        if (out_req != oa && q.size() > 0) begin
            void'(q.pop_front());
            oa      = ~oa;
            out_ack = oa;
        end
    endtask

    task automatic wait_accept();
        for (int k = 0; k < 4 * DEPTH && pending; k++) step();
        check(!pending, "R6 request not accepted", int'(pending), 0);
    endtask

    initial begin
        int n;
        rst_n = 0; in_req = 0; in_data = '0; out_ack = 0;
        ia_prev = 0; oa = 0; pending = 0; pend_data = '0;
        next_val = 8'h10; lfsr = 16'hACE1;
        repeat (4) @(negedge clk);
        rst_n = 1;
        step();
        // R1 reset state
        check(in_ack == 0 && out_req == 0, "R1 handshake outputs zero", int'({in_ack, out_req}), 0);
        check(empty == 1 && full == 0, "R1 flags after reset", int'({empty, full}), 2);

        // R9 fall-through latency, rising request (R2)
        push(8'hA5);
        step();
        check(in_ack == 1, "R9 in_ack after one edge", int'(in_ack), 1);
        n = 1;
        while (out_req == oa && n < 4 * DEPTH) begin step(); n++; end
        check(n == DEPTH, "R9 out_req latency", n, DEPTH);
        check(out_data == 8'hA5, "R4 first item data", int'(out_data), 8'hA5);
        pop(); step();
        check(empty == 1, "R7 empty after release", int'(empty), 1);

        // R2 falling request is an event too
        push(8'h3C);
        step();
        check(in_ack == 0, "R2 falling request accepted", int'(in_ack), 0);
        repeat (DEPTH) step();
        check(out_req != oa && out_data == 8'h3C, "R2 falling item delivered", int'(out_data), 8'h3C);
        pop(); step();

        // Fill to capacity without consuming
        for (int k = 0; k < DEPTH; k++) begin
            push(next_val); next_val++;
            wait_accept();
        end
        repeat (DEPTH) step();
        check(full == 1, "R8 full at capacity", int'(full), 1);

        // R3/R6 pending request while locked
        push(8'hEE);
        for (int k = 0; k < 2 * DEPTH; k++) begin
            step();
            check(in_ack == ia_prev && pending, "R3 locked stage holds", int'(in_ack), int'(ia_prev));
        end
        pop();
        n = 0;
        while (pending && n < 4 * DEPTH) begin step(); n++; end
        check(n == DEPTH, "R6 pending accepted after release", n, DEPTH);
        repeat (DEPTH) step();
        check(full == 1, "R8 full again", int'(full), 1);

        // Drain in order
        while (q.size() > 0) begin
            if (out_req != oa) pop();
            step();
        end
        repeat (DEPTH) step();
        check(empty == 1, "R5 drained empty", int'(empty), 1);

        // Mixed traffic
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (!pending && lfsr[0]) begin push(next_val); next_val++; end
            if (lfsr[3] || lfsr[5]) pop();
            step();
        end
        for (int k = 0; k < 20 * DEPTH; k++) begin
            if (out_req != oa) pop();
            step();
        end
        check(q.size() == 0 && empty == 1, "R5 all traffic delivered", q.size(), 0);
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

endmodule